// File: doc/BRIEF.md
# Synchronous DCE Interface Control Logic

This block sits between a synchronous serial port and the aggregate side of a multiplexer, and acts as the data communication equipment (DCE) end of the link. It turns the terminal's request-to-send and terminal-ready lines into a ready-for-sending answer. It reports carrier detect from the aggregate's health, and it reports data-set-ready unless a bit-error test is running. When the matching handshake line is off, it replaces the data in that direction with a steady mark.

Configuration bits can treat the terminal's request-to-send or terminal-ready line as permanently on. A test-override input can force ready-for-sending to a chosen value. All inputs are assumed to be already synchronized to the single system clock. Every output is registered, so any input change shows at the outputs one clock later.

Top module: `sdi_dce_ctrl`

## Requirements
- R1: While `rst_n` is low, after a clock edge, `dce_rfs`, `dce_dsr` and `dce_dcd` are 0, and `agg_txd` and `dte_rxd` are 1 (mark).
- R2: With no override active and terminal-ready effectively on, `dce_rfs` equals the effective request-to-send (`dte_rts` OR `cfg_rts_force`) sampled one clock earlier.
- R3: When `dce_rfs` is 0, `agg_txd` is 1. When `dce_rfs` is 1, `agg_txd` equals `dte_txd` sampled one clock earlier.
- R4: When `cfg_dtr_force` is 0 and `dte_dtr` was 0, with no override, `dce_rfs` is 0 and `agg_txd` is 1 on the next clock. When `cfg_dtr_force` is 1, `dte_dtr` has no effect.
- R5: When `test_rfs_en` was 1, `dce_rfs` equals the previous `test_rfs_val`. This takes priority over request-to-send and terminal-ready, and `agg_txd` follows rule R3 with that value.
- R6: `dce_dcd` equals (`agg_carrier` AND `agg_sync` AND NOT `agg_alarm`) sampled one clock earlier.
- R7: When `dce_dcd` is 0, `dte_rxd` is 1. When `dce_dcd` is 1, `dte_rxd` equals `agg_rxd` sampled one clock earlier.
- R8: `dce_dsr` equals NOT `bert_active` sampled one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dte_rts | input | 1 | Request-to-send from the terminal |
| dte_dtr | input | 1 | Terminal-ready from the terminal |
| dte_txd | input | 1 | Transmit data from the terminal |
| agg_rxd | input | 1 | Receive data from the aggregate |
| agg_carrier | input | 1 | Aggregate carrier present |
| agg_sync | input | 1 | Aggregate receiver synchronized |
| agg_alarm | input | 1 | Aggregate error condition |
| bert_active | input | 1 | Bit-error test sequence running |
| cfg_rts_force | input | 1 | 1: treat request-to-send as always on |
| cfg_dtr_force | input | 1 | 1: treat terminal-ready as always on |
| test_rfs_en | input | 1 | Enable test override of ready-for-sending |
| test_rfs_val | input | 1 | Value forced onto ready-for-sending |
| dce_rfs | output | 1 | Ready-for-sending to the terminal |
| dce_dsr | output | 1 | Data-set-ready to the terminal |
| dce_dcd | output | 1 | Carrier detect to the terminal |
| agg_txd | output | 1 | Gated transmit data toward the aggregate |
| dte_rxd | output | 1 | Gated receive data toward the terminal |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the terminal-ready hold and the test override. The bench drives terminal-ready off while the override forces ready-for-sending on. It then expects the override to win, with transmit data passing rather than mark. The second pair is carrier loss and an active bit-error test in one cycle. Here the bench expects data-set-ready and carrier detect to both drop, and receive data to sit at mark. Every vector's expected outputs are computed from the rules above, queued, and compared one clock later.

// File: rtl/sdi_pkg.sv
// Package: shared types for the synchronous DCE interface control logic.
// Assumes: nothing beyond a single system clock domain.
package sdi_pkg;
    // Line-forcing configuration for the terminal's control inputs.
    typedef struct packed {
        logic rts_force;
        logic dtr_force;
    } sdi_cfg_t;

    // Idle line level used whenever data is suppressed.
    localparam logic SDI_MARK = 1'b1;
endpackage

// File: rtl/sdi_tx_ctrl.sv
// Module: transmit-direction handshake.
// Derives the effective request-to-send and terminal-ready lines, applies the
// test override, registers ready-for-sending, and gates transmit data to mark
// when ready-for-sending is off.
// Assumes: inputs are synchronous to clk.
module sdi_tx_ctrl
    import sdi_pkg::*;
#(
    parameter logic MARK = SDI_MARK
) (
    input  logic     clk,
    input  logic     rst_n,
    input  sdi_cfg_t cfg,
    input  logic     rts,
    input  logic     dtr,
    input  logic     txd,
    input  logic     ovr_en,
    input  logic     ovr_val,
    output logic     rfs_q,
    output logic     txd_q
);
    logic rts_eff;
    logic dtr_eff;
    logic rfs_n;

    // Resolve the effective lines, with the override taking priority.
    always_comb begin
        rts_eff = rts | cfg.rts_force;
        dtr_eff = dtr | cfg.dtr_force;
        if (ovr_en) begin
            rfs_n = ovr_val;
        end else begin
            rfs_n = rts_eff & dtr_eff;
        end
    end

    // Register ready-for-sending and the gated transmit data together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rfs_q <= 1'b0;
            txd_q <= MARK;
        end else begin
            rfs_q <= rfs_n;
            txd_q <= rfs_n ? txd : MARK;
        end
    end

    p_rfs_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ovr_en && dtr_eff)) |-> (rfs_q == $past(rts_eff)));

    p_txd_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rfs_q |-> (txd_q == MARK));

    p_txd_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rfs_q) |-> (txd_q == $past(txd)));

    p_dtr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!dtr_eff && !ovr_en)) |-> !rfs_q);

    p_override_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ovr_en)) |-> (rfs_q == $past(ovr_val)));
endmodule

// File: rtl/sdi_rx_ctrl.sv
// Module: receive-direction carrier detect and data gating.
// Carrier detect is on only with carrier present, receiver synchronized and no
// aggregate alarm. Receive data is held at mark while carrier detect is off.
// Assumes: aggregate status flags are synchronous to clk.
module sdi_rx_ctrl
    import sdi_pkg::*;
#(
    parameter logic MARK = SDI_MARK
) (
    input  logic clk,
    input  logic rst_n,
    input  logic carrier,
    input  logic sync,
    input  logic alarm,
    input  logic rxd,
    output logic dcd_q,
    output logic rxd_q
);
    logic dcd_n;

    // Combine the aggregate health flags into carrier detect.
    always_comb dcd_n = carrier & sync & ~alarm;

    // Register carrier detect and the gated receive data together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcd_q <= 1'b0;
            rxd_q <= MARK;
        end else begin
            dcd_q <= dcd_n;
            rxd_q <= dcd_n ? rxd : MARK;
        end
    end

    p_alarm_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(alarm || !carrier || !sync)) |-> !dcd_q);

    p_rxd_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dcd_q |-> (rxd_q == MARK));

    p_rxd_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && dcd_q) |-> (rxd_q == $past(rxd)));
endmodule

// File: rtl/sdi_status.sv
// Module: data-set-ready generation.
// Data-set-ready is on in normal operation and off while the bit-error test
// sequence runs.
// Assumes: bert flag is synchronous to clk.
module sdi_status (
    input  logic clk,
    input  logic rst_n,
    input  logic bert,
    output logic dsr_q
);
    // Register data-set-ready from the test-running flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsr_q <= 1'b0;
        end else begin
            dsr_q <= ~bert;
        end
    end

    p_dsr_bert_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bert)) |-> !dsr_q);

    p_dsr_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!bert)) |-> dsr_q);
endmodule

// File: rtl/sdi_dce_ctrl.sv
// Module: top level of the synchronous DCE interface control logic.
// Bundles configuration and connects the transmit handshake, the receive
// gating and the data-set-ready status. All outputs are registered.
// Assumes: all inputs are already synchronized to clk; reset is synchronous.
module sdi_dce_ctrl
    import sdi_pkg::*;
#(
    parameter logic MARK = SDI_MARK
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dte_rts,
    input  logic dte_dtr,
    input  logic dte_txd,
    input  logic agg_rxd,
    input  logic agg_carrier,
    input  logic agg_sync,
    input  logic agg_alarm,
    input  logic bert_active,
    input  logic cfg_rts_force,
    input  logic cfg_dtr_force,
    input  logic test_rfs_en,
    input  logic test_rfs_val,
    output logic dce_rfs,
    output logic dce_dsr,
    output logic dce_dcd,
    output logic agg_txd,
    output logic dte_rxd
);
    sdi_cfg_t cfg;

    // Gather the configuration bits into one bundle.
    always_comb begin
        cfg.rts_force = cfg_rts_force;
        cfg.dtr_force = cfg_dtr_force;
    end

    sdi_tx_ctrl #(.MARK(MARK)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .rts     (dte_rts),
        .dtr     (dte_dtr),
        .txd     (dte_txd),
        .ovr_en  (test_rfs_en),
        .ovr_val (test_rfs_val),
        .rfs_q   (dce_rfs),
        .txd_q   (agg_txd)
    );

    sdi_rx_ctrl #(.MARK(MARK)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .carrier (agg_carrier),
        .sync    (agg_sync),
        .alarm   (agg_alarm),
        .rxd     (agg_rxd),
        .dcd_q   (dce_dcd),
        .rxd_q   (dte_rxd)
    );

    sdi_status u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .bert  (bert_active),
        .dsr_q (dce_dsr)
    );

    p_reset_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!dce_rfs && !dce_dsr && !dce_dcd && agg_txd == MARK && dte_rxd == MARK));
endmodule

// File: tb/tb_sdi_dce_ctrl.sv
// Scoreboard bench: the driver applies one vector per clock and queues the
// expected outputs; the monitor compares them one clock later.
module tb_sdi_dce_ctrl;
    localparam time CLK_PERIOD = 10;
    localparam int  WATCHDOG_CYCLES = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dte_rts = 0, dte_dtr = 0, dte_txd = 1, agg_rxd = 1;
    logic agg_carrier = 0, agg_sync = 0, agg_alarm = 0, bert_active = 0;
    logic cfg_rts_force = 0, cfg_dtr_force = 0, test_rfs_en = 0, test_rfs_val = 0;
    logic dce_rfs, dce_dsr, dce_dcd, agg_txd, dte_rxd;

    typedef struct {
        logic  rfs;
        logic  txd;
        logic  dcd;
        logic  rxd;
        logic  dsr;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 0;

    sdi_dce_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .dte_rts(dte_rts), .dte_dtr(dte_dtr), .dte_txd(dte_txd), .agg_rxd(agg_rxd),
        .agg_carrier(agg_carrier), .agg_sync(agg_sync), .agg_alarm(agg_alarm),
        .bert_active(bert_active), .cfg_rts_force(cfg_rts_force),
        .cfg_dtr_force(cfg_dtr_force), .test_rfs_en(test_rfs_en),
        .test_rfs_val(test_rfs_val),
        .dce_rfs(dce_rfs), .dce_dsr(dce_dsr), .dce_dcd(dce_dcd),
        .agg_txd(agg_txd), .dte_rxd(dte_rxd)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Compare one output against its expectation and count the check.
    task automatic check(input string tag, input string name, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, name, act, exp);
        end
    endtask

    // Driver: set a vector at the falling edge and queue its expected result.
    task automatic drive(input logic rst, input logic rts, input logic dtr, input logic txd,
                         input logic rxd, input logic car, input logic syn, input logic alm,
                         input logic bert, input logic frts, input logic fdtr,
                         input logic oen, input logic oval, input string tag);
        exp_t e;
        logic rfs_e;
        @(negedge clk);
        rst_n = rst; dte_rts = rts; dte_dtr = dtr; dte_txd = txd; agg_rxd = rxd;
        agg_carrier = car; agg_sync = syn; agg_alarm = alm; bert_active = bert;
        cfg_rts_force = frts; cfg_dtr_force = fdtr; test_rfs_en = oen; test_rfs_val = oval;
        rfs_e = oen ? oval : ((rts | frts) & (dtr | fdtr));
        if (!rst) begin
            e.rfs = 0; e.txd = 1; e.dcd = 0; e.rxd = 1; e.dsr = 0;
        end else begin
            e.rfs = rfs_e;
            e.txd = rfs_e ? txd : 1'b1;
            e.dcd = car & syn & ~alm;
            e.rxd = (car & syn & ~alm) ? rxd : 1'b1;
            e.dsr = ~bert;
        end
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: a quarter period after each rising edge, pop and compare.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD / 4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, "dce_rfs", dce_rfs, e.rfs);
                check(e.tag, "agg_txd", agg_txd, e.txd);
                check(e.tag, "dce_dcd", dce_dcd, e.dcd);
                check(e.tag, "dte_rxd", dte_rxd, e.rxd);
                check(e.tag, "dce_dsr", dce_dsr, e.dsr);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        //     rst rts dtr txd rxd car syn alm bert frts fdtr oen oval
        // R1: reset with every input active
        drive(0, 1, 1, 0, 0, 1, 1, 0, 0, 1, 1, 1, 1, "R1");
        drive(0, 1, 1, 0, 0, 1, 1, 0, 0, 1, 1, 1, 1, "R1");
        // R2: request-to-send on and off, observed
        drive(1, 1, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R2");
        drive(1, 0, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R2");
        drive(1, 1, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0, "R2");
        // R2: forced request-to-send ignores the line
        drive(1, 0, 1, 0, 1, 1, 1, 0, 0, 1, 0, 0, 0, "R2");
        // R3: data passes while ready, mark while not
        for (int i = 0; i < 6; i++)
            drive(1, 1, 1, logic'(i[0]), 1, 1, 1, 0, 0, 0, 0, 0, 0, "R3");
        drive(1, 0, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R3");
        // R4: terminal-ready off holds ready-for-sending off and data at mark
        drive(1, 1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R4");
        drive(1, 1, 0, 0, 0, 1, 1, 0, 0, 1, 0, 0, 0, "R4");
        // R4: forced terminal-ready ignores the line
        drive(1, 1, 0, 0, 0, 1, 1, 0, 0, 0, 1, 0, 0, "R4");
        // R5: override off beats a normal on state
        drive(1, 1, 1, 0, 0, 1, 1, 0, 0, 0, 0, 1, 0, "R5");
        // R5: override on beats terminal-ready off (same cycle as the hold)
        drive(1, 1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 1, 1, "R5");
        drive(1, 0, 0, 1, 0, 1, 1, 0, 0, 0, 0, 1, 1, "R5");
        // R6: each health flag drops carrier detect
        drive(1, 1, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R6");
        drive(1, 1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R6");
        drive(1, 1, 1, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0, "R6");
        drive(1, 1, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R6");
        // R7: receive data passes with carrier, mark without
        for (int i = 0; i < 4; i++)
            drive(1, 1, 1, 1, logic'(i[0]), 1, 1, 0, 0, 0, 0, 0, 0, "R7");
        drive(1, 1, 1, 1, 0, 1, 1, 1, 0, 0, 0, 0, 0, "R7");
        // R8: test sequence drops data-set-ready
        drive(1, 1, 1, 1, 0, 1, 1, 0, 1, 0, 0, 0, 0, "R8");
        drive(1, 1, 1, 1, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R8");
        // R6/R8: carrier loss and test sequence in the same cycle
        drive(1, 1, 1, 1, 0, 0, 1, 1, 1, 0, 0, 0, 0, "R8");
        // R1: return to reset mid-run
        drive(0, 1, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R1");
        drive(1, 1, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R2");
        while (exp_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule